// File: doc/BRIEF.md
# Clocked-Request Asynchronous SRAM Sequencer

This block sits between a simple valid/ready request port in the chip's clock domain and an external asynchronous static RAM whose control pins are all active low. One request carries a write flag, a word address, a write word and a per-byte write mask. The sequencer turns each request into a pin-level access stretched over a parameter-set number of clock cycles. The read count and the write-pulse count are chosen so that, at the chosen clock period, the memory's read cycle time (55 ns or 70 ns depending on grade) and its write pulse width are covered.

The control is one four-state machine. IDLE is the only state that accepts a request (transition IDLE→SETUP on an accepted access, IDLE→IDLE on an idle port or a write whose mask is all zero). SETUP presents the new address with every strobe high and, for a write, starts driving the data bus (SETUP→ACTIVE always). ACTIVE holds the strobes low for the programmed count (ACTIVE→ACTIVE while the count runs, ACTIVE→RECOVER on its last cycle). RECOVER raises every strobe while address and write data stay put (RECOVER→IDLE always). Read data is captured on the last ACTIVE cycle and returned with a one-cycle valid pulse. The data bus is split into separate in, out and output-enable vectors, so the pad ring builds the tri-state.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is low and right after it, req_ready is 1, sram_ce_n, sram_oe_n and sram_we_n are 1, every bit of sram_be_n is 1, sram_dq_oe is 0 and rsp_valid is 0. Reset is asynchronous and returns the pins to this state at once, even in the middle of an access.
- R2: req_ready is 1 only in IDLE. After a request is accepted, the next cycle is SETUP: req_ready is 0, all strobes are 1 and sram_addr carries the request address. The access takes SETUP, then the ACTIVE cycles, then one RECOVER cycle, and then req_ready returns.
- R3: A write holds sram_ce_n and sram_we_n at 0 and sram_oe_n at 1 for exactly WR_CYC cycles. sram_be_n[0] (lower byte) is the inverse of mask bit 0, and sram_be_n[1] (upper byte) is the inverse of mask bit 1.
- R4: A read holds sram_ce_n and sram_oe_n at 0 and sram_we_n at 1 for exactly RD_CYC cycles, with all of sram_be_n at 0.
- R5: sram_addr changes only on the clock that starts SETUP and stays stable through RECOVER. During a write, sram_dq_out equals the request data for every cycle in which sram_dq_oe is 1.
- R6: sram_dq_oe is 1 from SETUP through RECOVER of a write, is 0 for reads, and is never 1 while sram_oe_n is 0.
- R7: The read word is sampled from sram_dq_in on the last ACTIVE cycle. It appears on rsp_rdata with rsp_valid high for exactly one cycle, the RECOVER cycle, which is RD_CYC+1 cycles after SETUP.
- R8: A write whose mask is all zero is accepted and dropped. The strobes stay at 1, sram_dq_oe stays at 0 and req_ready stays at 1.
- R9: Between two accesses, sram_ce_n, sram_oe_n and sram_we_n are all 1 for at least one cycle, the RECOVER cycle.
- R10: rsp_valid pulses only for reads, once per read, and never for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (18) | Word address |
| req_wdata | input | DW (16) | Write word |
| req_mask | input | NB (2) | Byte write mask, bit 0 = lower byte |
| rsp_valid | output | 1 | One-cycle read return strobe |
| rsp_rdata | output | DW (16) | Returned read word |
| sram_addr | output | AW (18) | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | NB (2) | Byte enables, active low, bit 0 = lower byte |
| sram_dq_out | output | DW (16) | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DW (16) | Data returned from the memory |

## Verification
Two events land on the same clock edge. The read word is captured on the last ACTIVE cycle, and output enable is raised by that same edge. A capture taken one cycle late would see a released bus. The bench's memory model drives its stored word only while chip enable and output enable are low and write enable is high, and otherwise returns a fixed filler word. Every read response is therefore compared with a shadow copy of memory: the filler value shows an off-by-one capture, and a wrong cycle index for the valid pulse shows a misplaced return.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
    parameter int NB = 2
) (
    input  logic          rd,
    input  logic [NB-1:0] mask,
    output logic [NB-1:0] lane_n
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        // reads enable every lane; writes enable only masked lanes
        assign lane_n[g] = ~(rd | mask[g]);
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int NB     = 2,
    parameter int RD_CYC = 7,
    parameter int WR_CYC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NB-1:0] req_mask,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [NB-1:0] sram_be_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);
    localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [NB-1:0] mask_q;
    logic          wr_q;
    logic          tmr_last;
    logic [NB-1:0] lane_n;
    logic          accept;
    logic          start;
    logic          wr_next;
    logic          capture;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign start   = accept && !(req_write && (req_mask == '0));
    assign wr_next = (state_q == ST_IDLE) ? req_write : wr_q;
    assign capture = (state_q == ST_ACTIVE) && tmr_last && !wr_q;

    sram_cyc_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_SETUP),
        .load_val (wr_q ? WR_LOAD : RD_LOAD),
        .run      (state_q == ST_ACTIVE),
        .last     (tmr_last)
    );

    sram_lane_map #(.NB(NB)) i_lanes (
        .rd     (!wr_q),
        .mask   (mask_q),
        .lane_n (lane_n)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_ACTIVE;
            ST_ACTIVE:  if (tmr_last) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
                wr_q    <= req_write;
            end
        end
    end

    // registered pin outputs, computed from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_be_n  <= '1;
            sram_dq_oe <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            sram_ce_n  <= !(state_d == ST_ACTIVE);
            sram_oe_n  <= !((state_d == ST_ACTIVE) && !wr_next);
            sram_we_n  <= !((state_d == ST_ACTIVE) && wr_next);
            sram_be_n  <= (state_d == ST_ACTIVE) ? lane_n : '1;
            sram_dq_oe <= (state_d != ST_IDLE) && wr_next;
            rsp_valid  <= capture;
            if (capture) begin
                rsp_rdata <= sram_dq_in;
            end
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
    parameter int AW = 18,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic [NB-1:0] sram_be_n,
    input logic [DW-1:0] sram_dq_out,
    input logic          sram_dq_oe
);
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && !sram_dq_oe));

    a_r3_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    a_r4_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && (sram_be_n == '0)));

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> $stable(sram_addr));

    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    a_r6_drive_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && $past(sram_dq_oe)));

    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_selects_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (sram_be_n != '1));

    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_ce_n) |-> (sram_oe_n && sram_we_n));

    a_r10_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (sram_ce_n && $past(!sram_oe_n)));

endmodule

bind sram_seq_ctrl sram_seq_chk #(.AW(AW), .DW(DW), .NB(NB)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_be_n   (sram_be_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int NB = 2;
    localparam int RD_CYC = 7;
    localparam int WR_CYC = 6;
    localparam logic [DW-1:0] FILL = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [NB-1:0] sram_be_n;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [16];
    logic [DW-1:0] shadow [16];

    always #4 clk = ~clk;

    sram_seq_ctrl #(.AW(AW), .DW(DW), .NB(NB), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) i_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // memory model: drives only during a read strobe
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? model[sram_addr[3:0]] : FILL;

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
            if (!sram_be_n[0]) model[sram_addr[3:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_be_n[1]) model[sram_addr[3:0]][15:8] <= sram_dq_out[15:8];
        end
    end

    // {write, addr, data, mask}
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 18'h00003, 16'hA5C3, 2'b11},
        {1'b0, 18'h00003, 16'h0000, 2'b00},
        {1'b1, 18'h3FFF5, 16'h1234, 2'b01},
        {1'b0, 18'h3FFF5, 16'h0000, 2'b00},
        {1'b1, 18'h20007, 16'hBEEF, 2'b10},
        {1'b0, 18'h20007, 16'h0000, 2'b00},
        {1'b1, 18'h00009, 16'hFFFF, 2'b00},
        {1'b0, 18'h00009, 16'h0000, 2'b00},
        {1'b0, 18'h0000C, 16'h0000, 2'b00}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m);
        int idx = 0;
        int act = 0;
        int rsp_n = 0;
        int rsp_idx = -1;
        logic [DW-1:0] rsp_d = '0;
        bit lane_ok = 1;
        bit hold_ok = 1;
        bit drv_ok = 1;
        bit gap_ok = 1;
        bit setup_ok = 1;
        int n = w ? WR_CYC : RD_CYC;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (w && m == '0) begin
            for (int k = 0; k < 3; k++) begin
                chk(req_ready && sram_ce_n && sram_we_n && !sram_dq_oe && sram_be_n == '1,
                    "R8 zero-mask write dropped", {sram_ce_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1101);
                @(negedge clk);
            end
            return;
        end
        while (!req_ready && idx < 60) begin
            if (idx == 0)
                setup_ok = sram_ce_n && sram_oe_n && sram_we_n && (sram_addr == a) && (sram_dq_oe == w);
            if (!sram_ce_n) begin
                act++;
                if (sram_we_n != !w || sram_oe_n != w || sram_be_n != (w ? ~m : '0)) lane_ok = 0;
            end
            if (!sram_oe_n && sram_dq_oe) drv_ok = 0;
            if (sram_dq_oe != w) drv_ok = 0;
            if (sram_addr != a) hold_ok = 0;
            if (sram_dq_oe && sram_dq_out != d) hold_ok = 0;
            if (idx == n + 1 && !(sram_ce_n && sram_oe_n && sram_we_n)) gap_ok = 0;
            if (rsp_valid) begin
                rsp_n++; rsp_idx = idx; rsp_d = rsp_rdata;
            end
            @(negedge clk);
            idx++;
        end
        chk(setup_ok, "R2 setup cycle", 32'(setup_ok), 1);
        chk(idx == n + 2, "R2 access length", idx, n + 2);
        chk(act == n, w ? "R3 write active cycles" : "R4 read active cycles", act, n);
        chk(lane_ok, w ? "R3 write strobes/lanes" : "R4 read strobes/lanes", 32'(lane_ok), 1);
        chk(hold_ok, "R5 address/data hold", 32'(hold_ok), 1);
        chk(drv_ok, "R6 bus drive window", 32'(drv_ok), 1);
        chk(gap_ok, "R9 recover gap", 32'(gap_ok), 1);
        if (w) begin
            chk(rsp_n == 0, "R10 no response on write", rsp_n, 0);
            if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
            if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
        end else begin
            chk(rsp_n == 1 && rsp_idx == RD_CYC + 1, "R7 response timing", rsp_idx, RD_CYC + 1);
            chk(rsp_d == shadow[a[3:0]], "R7 read data", rsp_d, shadow[a[3:0]]);
        end
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            model[i] = 16'h1000 + 16'(i);
            shadow[i] = 16'h1000 + 16'(i);
        end
        #20;
        // R1 reset values
        chk(req_ready && sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == '1 && !sram_dq_oe && !rsp_valid,
            "R1 reset pins", {req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 6'b111100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sram_ce_n && !sram_dq_oe, "R1 after reset", {req_ready, sram_ce_n, sram_dq_oe}, 3'b110);

        for (int v = 0; v < NV; v++)
            access(VEC[v][36], VEC[v][35:18], VEC[v][17:2], VEC[v][1:0]);

        // back-to-back write then read of the upper address edge
        access(1'b1, 18'h3FFFF, 16'h5A5A, 2'b11);
        access(1'b0, 18'h3FFFF, 16'h0000, 2'b00);

        // R1: reset in the middle of a read
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00002;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sram_oe_n, "R4 read strobe before reset", sram_oe_n, 0);
        rst_n = 1'b0;
        #1;
        chk(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid,
            "R1 async reset mid-access", {req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 6'b111100);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 18'h00003, 16'h0000, 2'b00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule